// File: doc/BRIEF.md
# Control-Word Steered Register Datapath

This block is the execution half of a small processor: eight 16-bit general registers, two combinational read ports, one synchronous write port, and a shared function unit. The function unit is an adder/subtractor, a logic unit and a one-place shifter behind a single result mux. Nothing inside the block decides what happens next. A 16-bit control word, supplied fresh every cycle by an external sequencer, selects the operand registers and the bus-B source. It also selects the operation, the bus-D source, the destination register and whether that destination is written.

Bus A leaves the block as an address output and bus B leaves as a data output, so an attached memory can be addressed and written directly. Memory read data returns on the data input and can be steered into a register in place of the function-unit result. An immediate constant input can replace the second register operand. Four status flags describe the function-unit result, and a sequencer can use them to make branch decisions.

Control word layout, most significant bit first: destination select [15:13], A-source select [12:10], B-source select [9:7], B-mux select [6], function select [5:2], D-mux select [1], write enable [0].

Top module: `cwdp_datapath`

## Requirements
- R1: After reset every register reads as 0 on `addr_out`, whichever register the A-source select field [12:10] names.
- R2: `addr_out` equals the register named by field [12:10] in the same cycle, with no clock delay. When bit [6] is 0, `data_out` equals the register named by field [9:7].
- R3: When bit [6] is 1, `data_out` (bus B) equals `const_in`, and the function unit uses `const_in` as its B operand.
- R4: When bit [0] is 1, bus D is written into the register named by field [15:13] at the rising clock edge. When bit [0] is 0, no register changes.
- R5: Bit [1] selects bus D: 0 gives the function-unit result and 1 gives `data_in`. The flags always describe the function-unit result.
- R6: Function codes (field [5:2]) in the arithmetic group: 0000 A, 0001 A+1, 0010 A+B, 0011 A+B+1, 0100 A+~B, 0101 A+~B+1 (A-B), 0110 A-1, 0111 A. All results wrap modulo 2^16.
- R7: Logic codes: 1000 A&B, 1001 A|B, 1010 A^B, 1011 ~A, 1100 B. Code 1111 yields 0.
- R8: Shift codes: 1101 is B shifted right one place and 1110 is B shifted left one place. Zeros enter the vacated bit.
- R9: `flag_z` is 1 exactly when the function-unit result is all zeros, and `flag_n` equals result bit 15.
- R10: For codes 0000 to 0111, `flag_c` is the carry out of A plus the second addend plus the carry in. The second addend is 0 for 0000, 0001 and 0111; B for 0010 and 0011; ~B for 0100 and 0101; 0xFFFF for 0110. The carry in is 1 for 0001, 0011 and 0101 and 0 otherwise. `flag_v` is the signed overflow of that same sum. For every code from 1000 upward both flags are 0.
- R11: A register that is read and written in the same cycle shows its old value on the read ports until the edge, and its new value after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| ctrl_word | input | 16 | Packed control word for this cycle |
| const_in | input | 16 | Immediate operand for bus B |
| data_in | input | 16 | External data for bus D (memory read data) |
| addr_out | output | 16 | Bus A value |
| data_out | output | 16 | Bus B value |
| flag_c | output | 1 | Carry out of the arithmetic group |
| flag_v | output | 1 | Signed overflow of the arithmetic group |
| flag_z | output | 1 | Function-unit result is zero |
| flag_n | output | 1 | Function-unit result bit 15 |

## Verification
The read of a register and the write of that same register can fall in the same cycle. This case arises whenever the destination field equals the A- or B-source field with the write enable set. The bench provokes it with directed words such as an increment of a register onto itself, and with long streams of unconstrained control words in which such collisions are frequent. A reference model holding eight integers is judged before each edge against the old contents and updated only at the edge. Any forwarding or late write therefore shows up as a mismatch on `addr_out`, `data_out` or the flags.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;

    localparam int CW_W     = 16;
    localparam int RSEL_W   = 3;

    typedef enum logic [3:0] {
        FS_PASS_A  = 4'b0000,
        FS_INC_A   = 4'b0001,
        FS_ADD     = 4'b0010,
        FS_ADD_C   = 4'b0011,
        FS_ADD_NB  = 4'b0100,
        FS_SUB     = 4'b0101,
        FS_DEC_A   = 4'b0110,
        FS_PASS_A2 = 4'b0111,
        FS_AND     = 4'b1000,
        FS_OR      = 4'b1001,
        FS_XOR     = 4'b1010,
        FS_NOT_A   = 4'b1011,
        FS_PASS_B  = 4'b1100,
        FS_SHR_B   = 4'b1101,
        FS_SHL_B   = 4'b1110,
        FS_ZERO    = 4'b1111
    } fsel_e;

    typedef struct packed {
        logic [RSEL_W-1:0] dst;
        logic [RSEL_W-1:0] srca;
        logic [RSEL_W-1:0] srcb;
        logic              bsel_const;
        fsel_e             fsel;
        logic              dsel_ext;
        logic              wr;
    } ctrl_word_t;

endpackage

// File: rtl/cwdp_regfile.sv
module cwdp_regfile #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_a_addr,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data
);

    localparam int NREGS = 1 << ADDR_W;

    logic [NREGS-1:0][DATA_W-1:0] regs;

    for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[gi] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(gi))) begin
                regs[gi] <= wr_data;
            end
        end
    end

    assign rd_a_data = regs[rd_a_addr];
    assign rd_b_data = regs[rd_b_addr];

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (regs == $past(regs)));                        // R4

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[$past(wr_addr)] == $past(wr_data)));      // R4

endmodule

// File: rtl/cwdp_funit.sv
module cwdp_funit
    import cwdp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  fsel_e             fsel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result,
    output logic              carry,
    output logic              ovf
);

    logic [DATA_W-1:0] addend;
    logic              cin;
    logic [DATA_W:0]   sum;

    always_comb begin
        addend = '0;
        cin    = 1'b0;
        unique case (fsel)
            FS_INC_A:  cin = 1'b1;
            FS_ADD:    addend = opb;
            FS_ADD_C:  begin addend = opb;  cin = 1'b1; end
            FS_ADD_NB: addend = ~opb;
            FS_SUB:    begin addend = ~opb; cin = 1'b1; end
            FS_DEC_A:  addend = '1;
            default:   begin addend = '0; cin = 1'b0; end
        endcase
    end

    assign sum = {1'b0, opa} + {1'b0, addend} + {{DATA_W{1'b0}}, cin};

    always_comb begin
        result = '0;
        carry  = 1'b0;
        ovf    = 1'b0;
        if (!fsel[3]) begin
            result = sum[DATA_W-1:0];
            carry  = sum[DATA_W];
            ovf    = (opa[DATA_W-1] == addend[DATA_W-1]) &&
                     (sum[DATA_W-1] != opa[DATA_W-1]);
        end else begin
            unique case (fsel)
                FS_AND:    result = opa & opb;
                FS_OR:     result = opa | opb;
                FS_XOR:    result = opa ^ opb;
                FS_NOT_A:  result = ~opa;
                FS_PASS_B: result = opb;
                FS_SHR_B:  result = {1'b0, opb[DATA_W-1:1]};
                FS_SHL_B:  result = {opb[DATA_W-2:0], 1'b0};
                default:   result = '0;
            endcase
        end
    end

endmodule

// File: rtl/cwdp_datapath.sv
module cwdp_datapath
    import cwdp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW_W-1:0]   ctrl_word,
    input  logic [DATA_W-1:0] const_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out,
    output logic              flag_c,
    output logic              flag_v,
    output logic              flag_z,
    output logic              flag_n
);

    ctrl_word_t        cw;
    logic [DATA_W-1:0] bus_a;
    logic [DATA_W-1:0] reg_b;
    logic [DATA_W-1:0] bus_b;
    logic [DATA_W-1:0] bus_d;
    logic [DATA_W-1:0] fu_res;
    logic              fu_c;
    logic              fu_v;

    assign cw = ctrl_word_t'(ctrl_word);

    cwdp_regfile #(
        .DATA_W (DATA_W),
        .ADDR_W (RSEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cw.wr),
        .wr_addr   (cw.dst),
        .wr_data   (bus_d),
        .rd_a_addr (cw.srca),
        .rd_b_addr (cw.srcb),
        .rd_a_data (bus_a),
        .rd_b_data (reg_b)
    );

    assign bus_b = cw.bsel_const ? const_in : reg_b;

    cwdp_funit #(
        .DATA_W (DATA_W)
    ) u_fu (
        .fsel   (cw.fsel),
        .opa    (bus_a),
        .opb    (bus_b),
        .result (fu_res),
        .carry  (fu_c),
        .ovf    (fu_v)
    );

    assign bus_d    = cw.dsel_ext ? data_in : fu_res;
    assign addr_out = bus_a;
    assign data_out = bus_b;
    assign flag_c   = fu_c;
    assign flag_v   = fu_v;
    assign flag_z   = (fu_res == '0);
    assign flag_n   = fu_res[DATA_W-1];

    AST_MB_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        cw.bsel_const |-> (data_out == const_in));                // R3

    AST_LOGIC_NO_CV: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[5] |-> (!flag_c && !flag_v));                   // R10

    AST_Z_NOT_N: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z |-> !flag_n);                                      // R9

    AST_EXT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.wr && cw.dsel_ext && (cw.srca == cw.dst)) |=>
        (($past(ctrl_word[12:10]) != ctrl_word[12:10]) ||
         (addr_out == $past(data_in))));                          // R5

endmodule

// File: tb/tb_cwdp_datapath.sv
`timescale 1ns/1ps
module tb_cwdp_datapath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl_word = '0;
    logic [15:0] const_in = '0;
    logic [15:0] data_in = '0;
    logic [15:0] addr_out, data_out;
    logic        flag_c, flag_v, flag_z, flag_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] mregs [8];

    always #4 clk = ~clk;

    cwdp_datapath dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
        .const_in(const_in), .data_in(data_in),
        .addr_out(addr_out), .data_out(data_out),
        .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z), .flag_n(flag_n)
    );

    function automatic logic [15:0] mk(input int d, input int a, input int b,
        input bit mb, input int fs, input bit md, input bit rw);
        return {d[2:0], a[2:0], b[2:0], mb, fs[3:0], md, rw};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference: behavioural arithmetic on integers
    task automatic ref_fu(input int fs, input int a, input int b,
                          output int res, output int c, output int v);
        int y, ci, s;
        res = 0; c = 0; v = 0; y = 0; ci = 0;
        if (fs < 8) begin
            case (fs)
                1: ci = 1;
                2: y = b;
                3: begin y = b; ci = 1; end
                4: y = b ^ 'hFFFF;
                5: begin y = b ^ 'hFFFF; ci = 1; end
                6: y = 'hFFFF;
                default: y = 0;
            endcase
            s = a + y + ci;
            res = s & 'hFFFF;
            c = (s >> 16) & 1;
            v = (((a >> 15) & 1) == ((y >> 15) & 1)) && (((res >> 15) & 1) != ((a >> 15) & 1));
        end else begin
            case (fs)
                8:  res = a & b;
                9:  res = a | b;
                10: res = a ^ b;
                11: res = a ^ 'hFFFF;
                12: res = b;
                13: res = b >> 1;
                14: res = (b << 1) & 'hFFFF;
                default: res = 0;
            endcase
        end
    endtask

    // drive one word at negedge, compare before the edge, update model at edge
    task automatic step(input logic [15:0] cw, input logic [15:0] k, input logic [15:0] din);
        int d, a, b, fs, res, c, v, bb;
        bit mb, md, rw;
        string rtag;
        @(negedge clk);
        ctrl_word = cw; const_in = k; data_in = din;
        d = cw[15:13]; a = cw[12:10]; b = cw[9:7]; mb = cw[6];
        fs = cw[5:2]; md = cw[1]; rw = cw[0];
        #2;
        bb = mb ? int'(k) : int'(mregs[b]);
        ref_fu(fs, mregs[a], bb, res, c, v);
        rtag = (fs < 8) ? "R6" : ((fs == 13 || fs == 14) ? "R8" : "R7");
        chk(addr_out == mregs[a], "R2/R11 bus A", addr_out, mregs[a]);
        chk(data_out == bb[15:0], mb ? "R3 bus B const" : "R2/R11 bus B", data_out, bb);
        chk({flag_z, flag_n} == {res == 0, res[15]}, {"R9 flags ", rtag},
            {flag_z, flag_n}, {res == 0, res[15]});
        chk({flag_c, flag_v} == {c[0], v[0]}, {"R10 carry/ovf ", rtag},
            {flag_c, flag_v}, {c[0], v[0]});
        @(posedge clk);
        if (rw) mregs[d] = md ? din : res[15:0];
    endtask

    task automatic expect_reg(input int r, input int exp, input string tag);
        @(negedge clk);
        ctrl_word = mk(0, r, 0, 0, 0, 0, 0);
        #2;
        chk(addr_out == exp[15:0], tag, addr_out, exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mregs[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: every register clear after reset
        for (int i = 0; i < 8; i++) expect_reg(i, 0, "R1 reset value");

        // R5: load external data into each register
        for (int i = 0; i < 8; i++) step(mk(i, 0, 0, 0, 0, 1, 1), 16'h0, 16'h1111 * (i + 1));
        for (int i = 0; i < 8; i++) expect_reg(i, 16'h1111 * (i + 1), "R5 data_in written");

        // R4: write enable low leaves the destination untouched
        step(mk(2, 5, 0, 0, 0, 1, 0), 16'h0, 16'hDEAD);
        expect_reg(2, 16'h3333, "R4 no write when disabled");

        // R5: md=0 writes function result; flags follow result not data_in
        step(mk(4, 1, 2, 0, 2, 0, 1), 16'h0, 16'hFFFF);
        expect_reg(4, 16'h2222 + 16'h3333, "R5 function result written");

        // R11: increment a register onto itself
        step(mk(3, 3, 3, 0, 1, 0, 1), 16'h0, 16'h0);
        expect_reg(3, 16'h4445, "R11 self-increment after edge");

        // R3 and R6 boundaries with constants
        step(mk(0, 0, 0, 1, 0, 1, 1), 16'h0, 16'h7FFF);
        step(mk(1, 0, 0, 1, 2, 0, 1), 16'h0001, 16'h0);      // 7FFF+1 overflow
        expect_reg(1, 16'h8000, "R6 signed overflow add");
        step(mk(5, 1, 0, 1, 5, 0, 1), 16'h0001, 16'h0);      // 8000-1 overflow
        step(mk(6, 7, 0, 1, 0, 1, 1), 16'h0, 16'h0000);
        step(mk(6, 6, 0, 0, 6, 0, 1), 16'h0, 16'h0);          // 0-1
        expect_reg(6, 16'hFFFF, "R6 decrement wraps");
        step(mk(7, 6, 0, 0, 1, 0, 1), 16'h0, 16'h0);          // FFFF+1 -> 0, Z, C
        expect_reg(7, 0, "R6 increment wraps to zero");
        // R8 shift edges
        step(mk(0, 0, 0, 1, 13, 0, 1), 16'h8001, 16'h0);
        expect_reg(0, 16'h4000, "R8 shift right fills zero");
        step(mk(0, 0, 0, 1, 14, 0, 1), 16'h8001, 16'h0);
        expect_reg(0, 16'h0002, "R8 shift left drops msb");
        // R7 code 1111 gives zero
        step(mk(0, 6, 0, 1, 15, 0, 1), 16'hFFFF, 16'h0);
        expect_reg(0, 0, "R7 code 1111 zero");

        // every code, every mux combination, random stream
        for (int i = 0; i < 3000; i++) begin
            step(16'($urandom), 16'($urandom), 16'($urandom));
        end
        for (int i = 0; i < 8; i++) expect_reg(i, mregs[i], "R4 final register contents");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule